// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block shapes the strobe timing of register and data accesses on a parallel ATA interface. The interface has two channels, and each channel has two drives. Every access runs in three phases, all counted in bus clocks. First comes an address setup phase. Next comes an active phase, in which the read or write strobe is high. Last comes a recovery phase, in which the address is still driven but the strobe is low. When the recovery phase ends, a one-clock completion pulse is given and the block is ready again.

The per-drive timing values are loaded through a byte-wide configuration write port, and a combinational read port returns them. Each drive has a timing byte that packs an active count and a recovery code, and both use wrapped encodings. The address setup time comes from a two-bit field whose codes are not monotonic.

The two channels choose setup time differently. On the primary channel, each drive has its own setup field, and every access uses the slower of the two. On the secondary channel, one register is shared by both drives. That register also holds the secondary channel's interrupt-pending flag, which is cleared by writing one to it.

Top module: `ide_pio_timer`

Configuration map (`cfg_addr`):
- 0: primary drive 0 setup
- 1: primary drive 1 setup
- 2: shared secondary setup and interrupt flag
- 3 to 6: timing bytes of drives 0 to 3
- 7: reads zero

Drive index = {`req_chan`, `req_drv`}.

## Requirements
- R1: After reset, addresses 0 to 2 read 0x40, addresses 3 to 6 read 0x3F, and the interrupt flag is 0. With these values an access takes 2 setup, 3 active and 1 recovery clocks.
- R2: Active field (timing byte bits 7:4): a value n from 1 to 15 gives n clocks of strobe, and 0 gives 16 clocks.
- R3: Recovery code (timing byte bits 3:0): codes 1 to 14 give code+1 clocks, code 0 gives 16 clocks, and code 15 gives the minimum of 1 clock.
- R4: Setup field (bits 7:6 of a setup register): 01 gives 2 clocks, 10 gives 3, 00 gives 4, and 11 gives 5.
- R5: A primary-channel access to either drive uses the longer of the two primary setup times.
- R6: A secondary-channel access to either drive uses the shared setup field. The primary setup fields have no effect on it.
- R7: Bit 4 of the shared register is the interrupt flag. `sec_irq_set` sets it. Writing 1 to bit 4 clears it, and writing 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins. `sec_irq_pend` and the read value of bit 4 both show the flag.
- R8: An accepted access raises `ata_addr_en` and drives the latched channel and drive outputs. It then runs setup, active and recovery in that order. Only the strobe chosen by `req_write` goes high: write when 1, read when 0. After recovery, `acc_done` is high for exactly one clock, with `ata_addr_en` low and `req_ready` high.
- R9: `req_ready` is high only while idle. A request made during an access is not taken.
- R10: The timing values are captured when the request is accepted. A configuration write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| sec_irq_set | input | 1 | Sets the secondary interrupt flag |
| sec_irq_pend | output | 1 | Secondary interrupt flag |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request will be taken |
| req_chan | input | 1 | Channel of the request (1 = secondary) |
| req_drv | input | 1 | Drive within the channel |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ata_addr_en | output | 1 | Address phase active (setup, active, recovery) |
| ata_chan | output | 1 | Channel being accessed |
| ata_drv | output | 1 | Drive being accessed |
| ata_rd_stb | output | 1 | Read strobe, active high |
| ata_wr_stb | output | 1 | Write strobe, active high |
| acc_done | output | 1 | One-clock completion pulse |

## Verification
Accesses are measured by counting phase lengths at the ports. Each active value from 1 to 15 and the wrapped 0 are programmed on various drives, which checks the decode at every code against the register slot it was written to. The recovery codes 0, 14 and 15 are the wrapped and minimal cases, and these are what separate a correct decode from a plain code+1 mapping. All four setup codes are tried on the primary pair in both orders, so that taking the longer time can be told apart from reading the selected drive's own field or from comparing raw codes. The secondary channel is run with primary fields that disagree with it, and a timing write made in the middle of an access shows whether the values were captured at acceptance.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  // counter width able to hold a count of 16 clocks
  localparam int CNT_W  = 5;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] SETUP_RST  = 8'h40;
  localparam logic [BYTE_W-1:0] TIMING_RST = 8'h3F;
  localparam int IRQ_BIT = 4;

  // configuration map
  localparam int ADR_SU_P0 = 0;
  localparam int ADR_SU_P1 = 1;
  localparam int ADR_SU_SH = 2;
  localparam int ADR_TIM0  = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_t;

  // active nibble: 0 wraps to 16
  function automatic logic [CNT_W-1:0] act_clocks(input logic [3:0] f);
    return (f == 4'd0) ? CNT_W'(16) : CNT_W'(f);
  endfunction

  // recovery code: 0 -> 16, 15 -> 1, else code+1
  function automatic logic [CNT_W-1:0] rec_clocks(input logic [3:0] c);
    logic [CNT_W-1:0] r;
    if (c == 4'd0)       r = CNT_W'(16);
    else if (c == 4'hF)  r = CNT_W'(1);
    else                 r = CNT_W'(c) + CNT_W'(1);
    return r;
  endfunction

  // address setup code
  function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] c);
    logic [CNT_W-1:0] r;
    unique case (c)
      2'b01:   r = CNT_W'(2);
      2'b10:   r = CNT_W'(3);
      2'b00:   r = CNT_W'(4);
      default: r = CNT_W'(5);
    endcase
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] max_cnt(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int CFG_AW  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [BYTE_W-1:0]              cfg_wdata,
  output logic [BYTE_W-1:0]              cfg_rdata,
  input  logic                           irq_set,
  output logic                           irq_pend,
  output logic [NUM_DRV-1:0][BYTE_W-1:0] tim_bytes,
  output logic [1:0]                     su_p0,
  output logic [1:0]                     su_p1,
  output logic [1:0]                     su_sh
);

  localparam logic [CFG_AW-1:0] A_P0 = CFG_AW'(ADR_SU_P0);
  localparam logic [CFG_AW-1:0] A_P1 = CFG_AW'(ADR_SU_P1);
  localparam logic [CFG_AW-1:0] A_SH = CFG_AW'(ADR_SU_SH);

  logic [BYTE_W-1:0] p0_q, p1_q, sh_q;
  logic              flag_q;
  logic [NUM_DRV-1:0][BYTE_W-1:0] tim_q;

  // named events for checks
  logic wr_sh, clr_req;
  assign wr_sh   = cfg_we && (cfg_addr == A_SH);
  assign clr_req = wr_sh && cfg_wdata[IRQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= SETUP_RST;
      p1_q <= SETUP_RST;
      sh_q <= SETUP_RST;
    end else if (cfg_we) begin
      if (cfg_addr == A_P0) p0_q <= cfg_wdata;
      if (cfg_addr == A_P1) p1_q <= cfg_wdata;
      if (cfg_addr == A_SH) begin
        sh_q          <= cfg_wdata;
        sh_q[IRQ_BIT] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (irq_set)  flag_q <= 1'b1;
    else if (clr_req)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DRV; i++) tim_q[i] <= TIMING_RST;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_DRV; i++)
        if (cfg_addr == CFG_AW'(ADR_TIM0 + i)) tim_q[i] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_P0) cfg_rdata = p0_q;
    if (cfg_addr == A_P1) cfg_rdata = p1_q;
    if (cfg_addr == A_SH) begin
      cfg_rdata          = sh_q;
      cfg_rdata[IRQ_BIT] = flag_q;
    end
    for (int i = 0; i < NUM_DRV; i++)
      if (cfg_addr == CFG_AW'(ADR_TIM0 + i)) cfg_rdata = tim_q[i];
  end

  assign tim_bytes = tim_q;
  assign su_p0     = p0_q[7:6];
  assign su_p1     = p1_q[7:6];
  assign su_sh     = sh_q[7:6];
  assign irq_pend  = flag_q;

  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq_pend);
  assert_irq_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !irq_set) |=> !irq_pend);
  assert_irq_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sh && !cfg_wdata[IRQ_BIT] && irq_pend) |=> irq_pend);

endmodule

// File: rtl/ide_pio_sel.sv
module ide_pio_sel
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRV = 4
) (
  input  logic [NUM_DRV-1:0][BYTE_W-1:0] tim_bytes,
  input  logic [1:0]                     su_p0,
  input  logic [1:0]                     su_p1,
  input  logic [1:0]                     su_sh,
  input  logic                           chan,
  input  logic                           drv,
  output logic [CNT_W-1:0]               setup_clk,
  output logic [CNT_W-1:0]               active_clk,
  output logic [CNT_W-1:0]               recov_clk
);

  localparam int DRV_W = $clog2(NUM_DRV);

  logic [CNT_W-1:0] act_d [NUM_DRV];
  logic [CNT_W-1:0] rec_d [NUM_DRV];

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_dec
    assign act_d[g] = act_clocks(tim_bytes[g][7:4]);
    assign rec_d[g] = rec_clocks(tim_bytes[g][3:0]);
  end

  logic [DRV_W-1:0] idx;
  assign idx = DRV_W'({chan, drv});

  logic [CNT_W-1:0] prim_setup;
  assign prim_setup = max_cnt(setup_clocks(su_p0), setup_clocks(su_p1));

  assign setup_clk  = chan ? setup_clocks(su_sh) : prim_setup;
  assign active_clk = act_d[idx];
  assign recov_clk  = rec_d[idx];

  always_comb begin
    assert_setup_range_R4: assert (setup_clk >= CNT_W'(2) && setup_clk <= CNT_W'(5));
    assert_counts_nonzero_R2: assert (active_clk != '0 && recov_clk != '0);
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_chan,
  input  logic             req_drv,
  input  logic             req_write,
  output logic             req_ready,
  input  logic [CNT_W-1:0] setup_clk,
  input  logic [CNT_W-1:0] active_clk,
  input  logic [CNT_W-1:0] recov_clk,
  output logic             addr_en,
  output logic             chan_o,
  output logic             drv_o,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             done
);

  phase_t           ph_q, ph_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W-1:0] act_q, rec_q;
  logic             wr_q;

  // named events
  logic accept, last_cyc;
  assign accept   = req_valid && (ph_q == PH_IDLE);
  assign last_cyc = (cnt_q == '0);

  always_comb begin
    ph_nx  = ph_q;
    cnt_nx = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (accept) begin
        ph_nx  = PH_SETUP;
        cnt_nx = setup_clk - CNT_W'(1);
      end
      PH_SETUP: if (last_cyc) begin
        ph_nx  = PH_ACTIVE;
        cnt_nx = act_q - CNT_W'(1);
      end else cnt_nx = cnt_q - CNT_W'(1);
      PH_ACTIVE: if (last_cyc) begin
        ph_nx  = PH_RECOV;
        cnt_nx = rec_q - CNT_W'(1);
      end else cnt_nx = cnt_q - CNT_W'(1);
      default: if (last_cyc) begin
        ph_nx  = PH_IDLE;
        cnt_nx = '0;
      end else cnt_nx = cnt_q - CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
      chan_o  <= 1'b0;
      drv_o   <= 1'b0;
      addr_en <= 1'b0;
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      done    <= 1'b0;
    end else begin
      ph_q    <= ph_nx;
      cnt_q   <= cnt_nx;
      if (accept) begin
        act_q  <= active_clk;
        rec_q  <= recov_clk;
        wr_q   <= req_write;
        chan_o <= req_chan;
        drv_o  <= req_drv;
      end
      addr_en <= (ph_nx != PH_IDLE);
      rd_stb  <= (ph_nx == PH_ACTIVE) && !wr_q;
      wr_stb  <= (ph_nx == PH_ACTIVE) && wr_q;
      done    <= (ph_q == PH_RECOV) && last_cyc;
    end
  end

  assign req_ready = (ph_q == PH_IDLE);

  // strobe length watcher
  logic [CNT_W:0] stb_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stb_run_q <= '0;
    else if (rd_stb || wr_stb) stb_run_q <= stb_run_q + 1'b1;
    else                       stb_run_q <= '0;
  end

  assert_strobe_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_run_q <= (CNT_W+1)'(16));
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  assert_setup_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |-> !(rd_stb || wr_stb));
  assert_setup_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_en) |=> !(rd_stb || wr_stb));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_recov_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(addr_en) && !$past(rd_stb || wr_stb) && !addr_en));
  assert_accept_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (addr_en && !req_ready));
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> !req_ready);

endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int CFG_AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              sec_irq_set,
  output logic              sec_irq_pend,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_chan,
  input  logic              req_drv,
  input  logic              req_write,
  output logic              ata_addr_en,
  output logic              ata_chan,
  output logic              ata_drv,
  output logic              ata_rd_stb,
  output logic              ata_wr_stb,
  output logic              acc_done
);

  logic [NUM_DRV-1:0][BYTE_W-1:0] tim_bytes;
  logic [1:0]       su_p0, su_p1, su_sh;
  logic [CNT_W-1:0] setup_clk, active_clk, recov_clk;

  ide_pio_regs #(.NUM_DRV(NUM_DRV), .CFG_AW(CFG_AW)) regs_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .irq_set(sec_irq_set), .irq_pend(sec_irq_pend),
    .tim_bytes, .su_p0, .su_p1, .su_sh
  );

  ide_pio_sel #(.NUM_DRV(NUM_DRV)) sel_i (
    .tim_bytes, .su_p0, .su_p1, .su_sh,
    .chan(req_chan), .drv(req_drv),
    .setup_clk, .active_clk, .recov_clk
  );

  ide_pio_seq seq_i (
    .clk, .rst_n, .req_valid, .req_chan, .req_drv, .req_write, .req_ready,
    .setup_clk, .active_clk, .recov_clk,
    .addr_en(ata_addr_en), .chan_o(ata_chan), .drv_o(ata_drv),
    .rd_stb(ata_rd_stb), .wr_stb(ata_wr_stb), .done(acc_done)
  );

endmodule

// File: tb/ide_pio_timer_tb.sv
module ide_pio_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       sec_irq_set = 1'b0;
  logic       sec_irq_pend;
  logic       req_valid = 1'b0, req_ready, req_chan = 1'b0, req_drv = 1'b0, req_write = 1'b0;
  logic       ata_addr_en, ata_chan, ata_drv, ata_rd_stb, ata_wr_stb, acc_done;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ide_pio_timer dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int e_act(input int f);
    return (f == 0) ? 16 : f;
  endfunction
  function automatic int e_rec(input int c);
    case (c)
      0:       return 16;
      15:      return 1;
      default: return c + 1;
    endcase
  endfunction
  function automatic int e_su(input int c);
    case (c)
      1: return 2;
      2: return 3;
      0: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1 d = int'(cfg_rdata);
  endtask

  // run one access, count phases at the ports
  task automatic access(input bit ch, input bit dv, input bit w,
                        input bit midw, input int wa, input int wd,
                        output int s, output int a, output int r, output bit shape_ok);
    s = 0; a = 0; r = 0; shape_ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_drv = dv; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      if (acc_done) begin
        if (ata_addr_en || !req_ready) shape_ok = 0;
        break;
      end
      if (!ata_addr_en || req_ready || ata_chan != ch || ata_drv != dv) shape_ok = 0;
      if (ata_rd_stb || ata_wr_stb) begin
        if (ata_wr_stb != w || ata_rd_stb != !w || r != 0) shape_ok = 0;
        a++;
      end else if (a == 0) s++;
      else r++;
      if (midw && cyc == 1) begin
        cfg_we = 1'b1; cfg_addr = 3'(wa); cfg_wdata = 8'(wd);
      end
      if (midw && cyc == 2) cfg_we = 1'b0;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    @(negedge clk);
    if (acc_done) shape_ok = 0;
  endtask

  task automatic expect_access(input string tag, input bit ch, input bit dv, input bit w,
                               input int es, input int ea, input int er);
    int s, a, r; bit ok;
    access(ch, dv, w, 0, 0, 0, s, a, r, ok);
    check(s == es, {tag, " setup"}, s, es);
    check(a == ea, {tag, " active"}, a, ea);
    check(r == er, {tag, " recovery"}, r, er);
    check(ok, "R8 phase order/strobe/done", ok, 1);
  endtask

  task automatic t_reset();
    int d;
    for (int i = 0; i < 3; i++) begin
      rd(i, d); check(d == 'h40, "R1 setup reset", d, 'h40);
    end
    for (int i = 3; i < 7; i++) begin
      rd(i, d); check(d == 'h3F, "R1 timing reset", d, 'h3F);
    end
    check(sec_irq_pend == 0, "R1 irq reset", sec_irq_pend, 0);
    check(req_ready == 1 && ata_addr_en == 0, "R1 idle", req_ready, 1);
    expect_access("R1", 0, 0, 0, 2, 3, 1);
    expect_access("R1", 1, 1, 1, 2, 3, 1);
  endtask

  task automatic t_active_recovery();
    int pat [6] = '{'h02, 'hF1, 'h10, 'h8E, 'h4F, 'h7D};
    for (int k = 0; k < 6; k++) begin
      int dn = k % 4;
      wr(3 + dn, pat[k]);
      expect_access("R2/R3", dn[1], dn[0], k[0], 2,
                    e_act(pat[k] >> 4), e_rec(pat[k] & 15));
    end
    for (int f = 1; f < 16; f++) begin
      wr(4, (f << 4) | 'hF);
      expect_access("R2 sweep", 0, 1, 0, 2, f, 1);
    end
    wr(3, 'h3F); wr(4, 'h3F); wr(5, 'h3F); wr(6, 'h3F);
  endtask

  task automatic t_primary_setup();
    for (int c0 = 0; c0 < 4; c0++)
      for (int c1 = 0; c1 < 4; c1++) begin
        int e = (e_su(c0) > e_su(c1)) ? e_su(c0) : e_su(c1);
        wr(0, c0 << 6); wr(1, c1 << 6);
        expect_access("R4/R5", 0, (c0 + c1) % 2 == 1, 0, e, 3, 1);
      end
    wr(0, 'h40); wr(1, 'h40);
  endtask

  task automatic t_secondary_setup();
    wr(0, 'hC0); wr(1, 'h00);
    for (int c = 0; c < 4; c++) begin
      wr(2, c << 6);
      expect_access("R6 drv2", 1, 0, 0, e_su(c), 3, 1);
      expect_access("R6 drv3", 1, 1, 1, e_su(c), 3, 1);
    end
    wr(0, 'h40); wr(1, 'h40); wr(2, 'h40);
  endtask

  task automatic t_irq();
    int d;
    @(negedge clk); sec_irq_set = 1'b1;
    @(negedge clk); sec_irq_set = 1'b0;
    check(sec_irq_pend == 1, "R7 set", sec_irq_pend, 1);
    wr(2, 'h80);
    check(sec_irq_pend == 1, "R7 write zero keeps flag", sec_irq_pend, 1);
    rd(2, d); check(d == 'h90, "R7 readback with flag", d, 'h90);
    expect_access("R7 field written beside flag", 1, 0, 0, 3, 3, 1);
    wr(2, 'h50);
    check(sec_irq_pend == 0, "R7 write one clears", sec_irq_pend, 0);
    rd(2, d); check(d == 'h40, "R7 readback cleared", d, 'h40);
    @(negedge clk);
    sec_irq_set = 1'b1; cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 8'h50;
    @(negedge clk);
    sec_irq_set = 1'b0; cfg_we = 1'b0;
    check(sec_irq_pend == 1, "R7 set wins over clear", sec_irq_pend, 1);
    wr(2, 'h50);
  endtask

  task automatic t_busy_and_capture();
    int s, a, r; bit ok; int seen_ready;
    wr(5, 'h6C);
    access(1, 0, 1, 1, 5, 'h21, s, a, r, ok);
    check(s == 2 && a == 6 && r == 13, "R10 mid-write ignored", a * 100 + r, 613);
    check(ok, "R9 ready low during access", ok, 1);
    expect_access("R10 next access uses new value", 1, 0, 0, 2, 2, 2);
    // request held during access is not taken
    @(negedge clk);
    req_valid = 1'b1; req_chan = 1'b0; req_drv = 1'b0;
    @(negedge clk);
    req_chan = 1'b1; req_drv = 1'b1;
    seen_ready = 0;
    for (int i = 0; i < 4; i++) begin
      if (req_ready) seen_ready++;
      @(negedge clk);
    end
    check(seen_ready == 0, "R9 ready low while busy", seen_ready, 0);
    check(ata_chan == 0 && ata_drv == 0, "R9 active request unchanged",
          {ata_chan, ata_drv}, 0);
    req_valid = 1'b0;
    for (int i = 0; i < 40 && !acc_done; i++) @(negedge clk);
    @(negedge clk);
    check(ata_addr_en == 0, "R9 no access after drop", ata_addr_en, 0);
    wr(5, 'h3F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_active_recovery();
    t_primary_setup();
    t_secondary_setup();
    t_irq();
    t_busy_and_capture();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule